// File: doc/BRIEF.md
# Device ROM Header Checker

This block takes a device ROM image as a stream of bytes, one byte per clock, beginning at byte 0. It checks the image header on the fly. No copy of the image is kept.

Two checksums are computed over separate regions:

- an 8-bit CRC over the identifier bytes;
- a 32-bit CRC-32C over the data area, whose length comes from a field inside the header itself.

The block also pulls out the identifier, revision, data length, vendor ID and model ID. When the final byte of a frame has been taken, the block pulses a result strobe. That strobe carries the extracted fields, the two CRC verdicts, a size verdict and a fatal/warning classification.

Whether a checksum mismatch is fatal depends on the revision byte:

- **Revision 3:** the data CRC is binding and the identifier CRC is ignored.
- **Any other revision:** the identifier CRC is binding and a data CRC mismatch only raises a warning.

Frames may follow one another with no idle cycle between them. Upstream logic feeds the image bytes and reads the verdict on the strobe.

Top module: `drom_hdr_check`

## Requirements
- R1: `res_valid` pulses high for exactly one cycle, in the cycle after a byte with `in_valid` and `in_last` is accepted. The next accepted byte is byte 0 of a new frame. Cycles with `in_valid` low do not advance the frame and have no effect.
- R2: `res_uid_ok` is 1 when the CRC8 over bytes 1..8 matches byte 0. The CRC8 uses polynomial 0x07 and initial value 0xFF. Each byte is XORed into the register and then shifted MSB-first eight times. There is no final inversion.
- R3: `res_uid` is bytes 1..8 read little-endian, so byte 1 is bits 7:0.
- R4: `res_data_ok` is 1 when the reflected CRC-32C (reversed polynomial 0x82F63B78, initial value all ones, final inversion) over bytes 13 to 12+length matches the little-endian word in bytes 9..12.
- R5: `res_rev` is byte 13. `res_len` is the low 10 bits of the little-endian word in bytes 14..15; the upper 6 bits of byte 15 are ignored. `res_vendor` is little-endian bytes 16..17 and `res_model` is little-endian bytes 18..19.
- R6: `res_size_err` is 1 when the number of bytes in the frame differs from length+13, or when it is below 22.
- R7: For revision 3, `res_fatal` = size error OR data CRC mismatch, and `res_warn` is 0. An identifier CRC mismatch alone is not fatal.
- R8: For any revision other than 3, `res_fatal` = size error OR identifier CRC mismatch, and `res_warn` is 1 exactly when the data CRC mismatches.
- R9: Frames may be streamed back to back with no idle cycle, and each frame still gets its own correct result.
- R10: After reset, `res_valid` is 0. A frame that was cut off by reset produces no result, and the next byte starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte on `in_data` is accepted this cycle |
| in_data | input | 8 | Image byte |
| in_last | input | 1 | Accepted byte is the final byte of the frame |
| res_valid | output | 1 | Result strobe, one cycle |
| res_uid | output | 64 | Identifier |
| res_rev | output | 8 | ROM revision |
| res_len | output | 10 | Data area length |
| res_vendor | output | 16 | Vendor ID |
| res_model | output | 16 | Model ID |
| res_uid_ok | output | 1 | Identifier CRC8 matches |
| res_data_ok | output | 1 | Data CRC-32C matches |
| res_size_err | output | 1 | Frame size disagrees with header |
| res_fatal | output | 1 | Image must be rejected |
| res_warn | output | 1 | Non-fatal data CRC mismatch |

## Verification
The stimulus frames vary along several independent axes:

- **Which CRC is corrupted, crossed with revision 3 versus other revisions.** This separates the two fatal policies from each other and from plain CRC computation.
- **Data lengths from the 9-byte minimum to 1023.** This shows that the CRC region follows the length field and that the upper bits of byte 15 are masked.
- **Frames one byte too long and three bytes too short.** These show the size check is independent of the CRCs.
- **Idle gaps inside a frame and back-to-back frames.** These tell stall handling apart from frame-boundary handling.
- **A 15-byte stub and a frame abandoned by reset.** These cover the minimum-size rule and the restart rule.

// File: rtl/drom_pkg.sv
// Shared constants and CRC step functions for the ROM header checker.
// Assumes bytes are presented in image order starting at byte 0.
package drom_pkg;
    localparam int          DATA_START = 13;   // first byte of the data area
    localparam int          HDR_BYTES  = 20;   // bytes captured for field decode
    localparam int          MIN_IMAGE  = 22;   // smallest legal image
    localparam int          LEN_W      = 10;   // data length field width
    localparam int          CNT_W      = 12;   // byte counter width (saturating)
    localparam logic [7:0]  CRC8_POLY  = 8'h07;
    localparam logic [7:0]  CRC8_INIT  = 8'hFF;
    localparam logic [31:0] CRC32_POLY = 32'h82F63B78;
    localparam logic [31:0] CRC32_INIT = 32'hFFFF_FFFF;
    localparam logic [7:0]  STRICT_REV = 8'd3;

    // One byte of MSB-first CRC8.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c ^ b;
        for (int i = 0; i < 8; i++)
            r = {r[6:0], 1'b0} ^ (r[7] ? CRC8_POLY : 8'h00);
        return r;
    endfunction

    // One byte of reflected CRC-32C, unrolled into a parallel update.
    function automatic logic [31:0] crc32c_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++)
            r = {1'b0, r[31:1]} ^ (r[0] ? CRC32_POLY : 32'h0);
        return r;
    endfunction
endpackage

// File: rtl/drom_crc8_unit.sv
// Identifier CRC8 accumulator. clr loads the initial value; en folds in one byte.
// Assumes clr and en are never both high.
module drom_crc8_unit
    import drom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    // Accumulate one byte per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= CRC8_INIT;
        else if (clr) crc <= CRC8_INIT;
        else if (en)  crc <= crc8_step(crc, din);
    end

    // R2
    crc8_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/drom_crc32c_unit.sv
// Data-area CRC-32C accumulator, one byte per cycle, register holds the
// non-inverted remainder. Assumes clr and en are never both high.
module drom_crc32c_unit
    import drom_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    // Accumulate one byte per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= CRC32_INIT;
        else if (clr) crc <= CRC32_INIT;
        else if (en)  crc <= crc32c_step(crc, din);
    end

    // R4
    crc32_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc));
endmodule

// File: rtl/drom_hdr_capture.sv
// Holds the first NBYTES bytes of the frame, one register per byte position.
// Assumes idx is the position of the byte written this cycle.
module drom_hdr_capture
    import drom_pkg::*;
#(
    parameter int NBYTES = HDR_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [CNT_W-1:0]    idx,
    input  logic [7:0]          din,
    output logic [NBYTES*8-1:0] hdr
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        // Latch byte g of the frame when it arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hdr[g*8 +: 8] <= 8'h00;
            else if (wr && idx == CNT_W'(g))
                hdr[g*8 +: 8] <= din;
        end
    end
endmodule

// File: rtl/drom_hdr_check.sv
// Streaming ROM header checker. Tracks the byte position, steers bytes to the
// two CRC units and the header capture, and classifies the frame on in_last.
// Assumes one byte per in_valid cycle; outputs are meaningful while res_valid.
module drom_hdr_check
    import drom_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        res_valid,
    output logic [63:0] res_uid,
    output logic [7:0]  res_rev,
    output logic [9:0]  res_len,
    output logic [15:0] res_vendor,
    output logic [15:0] res_model,
    output logic        res_uid_ok,
    output logic        res_data_ok,
    output logic        res_size_err,
    output logic        res_fatal,
    output logic        res_warn
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam int               UID_LO  = 1;
    localparam int               UID_HI  = 8;

    logic                   sof;
    logic [CNT_W-1:0]       cnt;
    logic [CNT_W-1:0]       idx;
    logic [HDR_BYTES*8-1:0] hdr;
    logic [7:0]             crc8_q;
    logic [31:0]            crc32_q;
    logic [LEN_W-1:0]       len_f;
    logic [CNT_W-1:0]       area_end;
    logic                   crc8_en, crc32_en, first_byte;
    logic                   strict;

    assign idx        = sof ? '0 : cnt;
    assign first_byte = in_valid && (idx == '0);
    assign len_f      = {hdr[121:120], hdr[119:112]};
    assign area_end   = CNT_W'(len_f) + CNT_W'(DATA_START);
    assign crc8_en    = in_valid && idx >= CNT_W'(UID_LO) && idx <= CNT_W'(UID_HI);
    assign crc32_en   = in_valid && idx >= CNT_W'(DATA_START) &&
                        (idx < CNT_W'(DATA_START + 3) || idx < area_end);

    // Frame position tracking and result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof       <= 1'b1;
            cnt       <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid && in_last;
            if (in_valid) begin
                sof <= in_last;
                cnt <= (idx == CNT_MAX) ? idx : idx + 1'b1;
            end
        end
    end

    drom_crc8_unit u_crc8 (
        .clk(clk), .rst_n(rst_n), .clr(first_byte), .en(crc8_en),
        .din(in_data), .crc(crc8_q)
    );

    drom_crc32c_unit u_crc32 (
        .clk(clk), .rst_n(rst_n), .clr(first_byte), .en(crc32_en),
        .din(in_data), .crc(crc32_q)
    );

    drom_hdr_capture #(.NBYTES(HDR_BYTES)) u_hdr (
        .clk(clk), .rst_n(rst_n), .wr(in_valid), .idx(idx),
        .din(in_data), .hdr(hdr)
    );

    // Field decode and verdict classification.
    always_comb begin
        res_uid      = hdr[UID_HI*8+7 : UID_LO*8];
        res_rev      = hdr[111:104];
        res_len      = len_f;
        res_vendor   = hdr[143:128];
        res_model    = hdr[159:144];
        res_uid_ok   = (crc8_q == hdr[7:0]);
        res_data_ok  = (~crc32_q == hdr[103:72]);
        res_size_err = (cnt != area_end) || (cnt < CNT_W'(MIN_IMAGE));
        strict       = (res_rev == STRICT_REV);
        res_fatal    = res_size_err || (strict ? !res_data_ok : !res_uid_ok);
        res_warn     = !strict && !res_data_ok;
    end

    // R1
    strobe_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> sof);
    // R6
    size_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_size_err) |-> res_fatal);
    // R7
    strict_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_rev == STRICT_REV && !res_data_ok) |-> (res_fatal && !res_warn));
    // R8
    legacy_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_rev != STRICT_REV && !res_uid_ok) |-> res_fatal);
endmodule

// File: tb/drom_hdr_check_bench.sv
module drom_hdr_check_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic res_valid, res_uid_ok, res_data_ok, res_size_err, res_fatal, res_warn;
    logic [63:0] res_uid;
    logic [7:0]  res_rev;
    logic [9:0]  res_len;
    logic [15:0] res_vendor, res_model;

    always #5 clk = ~clk;

    drom_hdr_check u_drom_hdr_check (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .res_valid(res_valid), .res_uid(res_uid),
        .res_rev(res_rev), .res_len(res_len), .res_vendor(res_vendor),
        .res_model(res_model), .res_uid_ok(res_uid_ok), .res_data_ok(res_data_ok),
        .res_size_err(res_size_err), .res_fatal(res_fatal), .res_warn(res_warn)
    );

    typedef struct packed {
        int len; int rev; bit bad_uid; bit bad_data; int delta; bit gap;
    } vec_t;
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{9,    1, 1'b0, 1'b0,  0, 1'b0},
        '{40,   1, 1'b1, 1'b0,  0, 1'b0},
        '{40,   1, 1'b0, 1'b1,  0, 1'b1},
        '{100,  3, 1'b1, 1'b0,  0, 1'b0},
        '{100,  3, 1'b0, 1'b1,  0, 1'b0},
        '{1023, 2, 1'b0, 1'b0,  0, 1'b1},
        '{30,   1, 1'b0, 1'b0,  1, 1'b0},
        '{30,   3, 1'b0, 1'b0, -3, 1'b0}
    };

    int total = 0, bad = 0;
    logic [7:0] frame [0:1100];

    localparam int NE = 16;
    int exp_n = 0, log_n = 0;
    logic [63:0] e_uid [NE];
    logic [7:0]  e_rev [NE];
    logic [9:0]  e_len [NE];
    logic [15:0] e_ven [NE], e_mod [NE];
    bit e_uok [NE], e_dok [NE], e_size [NE], e_fatal [NE], e_warn [NE];
    bit e_full [NE], e_dmeaning [NE];
    logic [63:0] l_uid [NE];
    logic [7:0]  l_rev [NE];
    logic [9:0]  l_len [NE];
    logic [15:0] l_ven [NE], l_mod [NE];
    bit l_uok [NE], l_dok [NE], l_size [NE], l_fatal [NE], l_warn [NE];

    // Record every result strobe away from the active edge.
    always @(negedge clk) begin
        if (rst_n && res_valid && log_n < NE) begin
            l_uid[log_n] = res_uid;  l_rev[log_n] = res_rev;  l_len[log_n] = res_len;
            l_ven[log_n] = res_vendor; l_mod[log_n] = res_model;
            l_uok[log_n] = res_uid_ok; l_dok[log_n] = res_data_ok;
            l_size[log_n] = res_size_err; l_fatal[log_n] = res_fatal; l_warn[log_n] = res_warn;
            log_n = log_n + 1;
        end
    end

    function automatic logic [7:0] ref_crc8(input logic [7:0] f [0:1100]);
        logic [7:0] c = 8'hFF;
        for (int i = 1; i <= 8; i++) begin
            c = c ^ f[i];
            for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [31:0] ref_crc32(input logic [7:0] f [0:1100], input int len);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 13; i < 13 + len; i++) begin
            c = c ^ {24'h0, f[i]};
            for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Build a frame and record what its result should be.
    task automatic build(input int len, input int rev, input bit bu, input bit bd, input int n, input int seed);
        logic [7:0] c8;
        logic [31:0] c32;
        logic [15:0] ven, mdl;
        ven = 16'(seed * 1000 + 16'h1234);
        mdl = 16'(seed * 77 + 16'h0a0b);
        for (int i = 1; i <= 8; i++) frame[i] = 8'(seed * 31 + i * 17 + 1);
        frame[13] = 8'(rev);
        frame[14] = len[7:0];
        frame[15] = {6'b110100, len[9:8]};
        frame[16] = ven[7:0]; frame[17] = ven[15:8];
        frame[18] = mdl[7:0]; frame[19] = mdl[15:8];
        for (int i = 20; i <= 1100; i++) frame[i] = 8'(i * 7 + seed * 13 + 5);
        c8 = ref_crc8(frame);
        frame[0] = c8 ^ (bu ? 8'h01 : 8'h00);
        c32 = ref_crc32(frame, len) ^ (bd ? 32'h0000_0100 : 32'h0);
        frame[9] = c32[7:0]; frame[10] = c32[15:8]; frame[11] = c32[23:16]; frame[12] = c32[31:24];
        e_uid[exp_n] = {frame[8], frame[7], frame[6], frame[5], frame[4], frame[3], frame[2], frame[1]};
        e_rev[exp_n] = 8'(rev); e_len[exp_n] = 10'(len); e_ven[exp_n] = ven; e_mod[exp_n] = mdl;
        e_size[exp_n] = (n != len + 13) || (n < 22);
        e_uok[exp_n] = !bu; e_dok[exp_n] = !bd;
        e_fatal[exp_n] = e_size[exp_n] || ((rev == 3) ? bd : bu);
        e_warn[exp_n] = (rev != 3) && bd;
        e_full[exp_n] = (n >= 20);
        e_dmeaning[exp_n] = (n >= len + 13) && (n >= 20);
        exp_n++;
    endtask

    // Stream n bytes of the frame, optionally with idle gaps.
    task automatic send(input int n, input bit gap, input bit with_last, input bit tail_idle);
        for (int i = 0; i < n; i++) begin
            if (gap && (i % 3 == 1)) begin
                in_valid = 1'b0; in_last = 1'b1; in_data = 8'hA5;
                @(posedge clk); #1;
            end
            in_valid = 1'b1; in_data = frame[i]; in_last = with_last && (i == n - 1);
            @(posedge clk); #1;
        end
        if (tail_idle) begin in_valid = 1'b0; in_last = 1'b0; end
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "res_valid after reset", 64'(res_valid), 64'd0);

        // Table of frames: R2..R8, gaps for R1
        for (int v = 0; v < NV; v++) begin
            build(VECS[v].len, VECS[v].rev, VECS[v].bad_uid, VECS[v].bad_data,
                  VECS[v].len + 13 + VECS[v].delta, v + 1);
            send(VECS[v].len + 13 + VECS[v].delta, VECS[v].gap, 1'b1, 1'b1);
            repeat (2) @(posedge clk); #1;
        end

        // R9: back-to-back frames with no idle cycle
        build(12, 1, 1'b0, 1'b0, 25, 20);
        send(25, 1'b0, 1'b1, 1'b0);
        build(20, 3, 1'b1, 1'b0, 33, 21);
        send(33, 1'b0, 1'b1, 1'b1);
        repeat (2) @(posedge clk); #1;

        // R6: stub shorter than the minimum image
        build(2, 1, 1'b0, 1'b0, 15, 22);
        send(15, 1'b0, 1'b1, 1'b1);
        repeat (2) @(posedge clk); #1;

        // R10: frame cut off by reset, then a clean frame
        build(50, 1, 1'b0, 1'b0, 63, 23);
        exp_n--;
        send(10, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "res_valid after mid-frame reset", 64'(res_valid), 64'd0);
        #1;
        build(50, 1, 1'b0, 1'b0, 63, 24);
        send(63, 1'b0, 1'b1, 1'b1);
        repeat (3) @(posedge clk); #1;

        chk("R1", "result count", 64'(log_n), 64'(exp_n));
        for (int k = 0; k < exp_n && k < log_n; k++) begin
            chk("R6", "size_err", 64'(l_size[k]), 64'(e_size[k]));
            chk("R7", "fatal", 64'(l_fatal[k]), 64'(e_fatal[k]));
            if (e_full[k]) begin
                chk("R3", "uid", l_uid[k], e_uid[k]);
                chk("R5", "rev", 64'(l_rev[k]), 64'(e_rev[k]));
                chk("R5", "len", 64'(l_len[k]), 64'(e_len[k]));
                chk("R5", "vendor", 64'(l_ven[k]), 64'(e_ven[k]));
                chk("R5", "model", 64'(l_mod[k]), 64'(e_mod[k]));
                chk("R2", "uid_ok", 64'(l_uok[k]), 64'(e_uok[k]));
            end
            if (e_dmeaning[k]) begin
                chk("R4", "data_ok", 64'(l_dok[k]), 64'(e_dok[k]));
                chk("R8", "warn", 64'(l_warn[k]), 64'(e_warn[k]));
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule